// File: doc/BRIEF.md
# Debug-Aware Clock Divide Controller

This block chooses the divide ratio of a small processor's system clock. The core runs either at full rate (divide by 1) or in a low-power mode that divides the clock by 256. The block also knows when an on-chip debug engine has halted the core. It can force the clock back to full rate when debug is entered, and it gates the system clock off between debug commands. It also runs a crystal warmup counter that, once done, switches the clock source without a glitch.

All of it is reference-clock synchronous. The divider produces a one-cycle `clk_en` pulse per divided period, and a downstream clock gate uses that pulse. The warmup counter is the only counter that runs while the halted core waits for a debug command. The divide counter is frozen while the clock is gated. A request to enter low power is refused while debug is active, and also until one instruction has retired after debug exit.

Top module: `clkdiv_dbg_ctrl`

## Requirements
- R1: Reset sets divide ratio 1 with `clk_en` high, `lowpwr_on` low, `active_src` 0 and `src_switch_stb` low.
- R2: A `lp_set_req` pulse, when accepted, raises `lowpwr_on` in the next cycle. `div_ratio` reads 256 one cycle after that. `div_ratio` only ever holds 1 or 256.
- R3: Outside debug, `clk_en` is high in every cycle at divide 1 and high in exactly one cycle of every 256 at divide 256.
- R4: When low power is cleared by `lp_clr_req`, `lowpwr_on` drops in the next cycle. `div_ratio` returns to 1 only in the cycle after a `clk_en` pulse. The only exception is a forced switchback (R5).
- R5: If `swb_en` is 1 in a cycle where `bkpt_hit` or `host_dbg_req` is high, the next cycle shows `div_ratio` 1 and `lowpwr_on` 0.
- R6: While debug is active, `clk_en` is 0 in every cycle where `dbg_cmd_busy` is low. The divide counter holds its count during those cycles. While `dbg_cmd_busy` is high, `clk_en` pulses at the current ratio.
- R7: With `swb_en` at 0, a debug entry leaves `div_ratio` and `lowpwr_on` unchanged.
- R8: `lp_set_req` is ignored while debug is active and after `dbg_exit` until an `instr_retire` pulse. Ignored means `lowpwr_on` stays 0. After that pulse the request is accepted again.
- R9: A `src_req` pulse at divide 1 starts the warmup. Exactly WARM_CYCLES+1 clock edges after the edge that captured the request, `active_src` takes `src_target` and `src_switch_stb` is high for one cycle. `active_src` never changes without the strobe.
- R10: The warmup keeps counting while debug is active with the clock gated, and the switch then happens without waiting for a divided boundary. Outside debug at divide 256, the switch waits for a boundary, so the strobe follows a cycle with `clk_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_set_req | input | 1 | Request to set the low-power enable |
| lp_clr_req | input | 1 | Request to clear the low-power enable |
| swb_en | input | 1 | Switchback to full rate on debug entry |
| bkpt_hit | input | 1 | Breakpoint match, enters debug |
| host_dbg_req | input | 1 | Host debug command, enters debug |
| dbg_exit | input | 1 | Leave active debug |
| dbg_cmd_busy | input | 1 | A debug command is executing |
| instr_retire | input | 1 | One instruction retired |
| src_req | input | 1 | Start warmup of a new clock source |
| src_target | input | SRC_W | Source to switch to after warmup |
| div_ratio | output | RATIO_W | Active divide ratio (1 or 256) |
| clk_en | output | 1 | System clock gate enable, one pulse per divided period |
| lowpwr_on | output | 1 | Low-power enable state |
| active_src | output | SRC_W | Clock source in use |
| src_switch_stb | output | 1 | One-cycle strobe on a source switch |

## Verification
The results arrive at different latencies. The low-power flag follows a request after one edge and the ratio after two. A switchback shows after one edge. The first warmup strobe shows WARM_CYCLES+1 edges after the capturing edge. A ratio return waits for the next divided boundary, up to 256 cycles. The bench drives inputs at falling edges and samples at the next falling edge. It counts edges from the capturing edge, so each check lands in the exact cycle a result is due. For the boundary-bound results, the bench loops sample by sample and records the `clk_en` value that came just before the change. Ignored requests are checked by watching `lowpwr_on` after the request and before any retire pulse.

// File: rtl/clkdiv_pkg.sv
// Shared types for the debug-aware clock divide controller.
package clkdiv_pkg;
    typedef enum logic {
        SEL_FULL = 1'b0,
        SEL_SLOW = 1'b1
    } div_sel_e;
endpackage

// File: rtl/clkdiv_mode_ctrl.sv
// Mode control: tracks debug state and the post-debug first-instruction
// flag, owns the low-power enable bit and the selected divide ratio.
// Assumes debug entry/exit inputs are single-cycle events in clk domain.
module clkdiv_mode_ctrl
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lp_set_req,
    input  logic     lp_clr_req,
    input  logic     swb_en,
    input  logic     dbg_enter,
    input  logic     dbg_exit,
    input  logic     instr_retire,
    input  logic     tick,
    output logic     dbg_active,
    output logic     first_after_dbg,
    output logic     lp_en,
    output logic     force_full,
    output div_sel_e div_sel
);
    logic set_ok;

    // Switchback and set-permission decode.
    always_comb begin
        force_full = dbg_enter && swb_en;
        set_ok     = lp_set_req && !dbg_active && !first_after_dbg && !dbg_enter;
    end

    // Debug-active state: entry event sets, exit clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                        dbg_active <= 1'b0;
        else if (dbg_enter)                dbg_active <= 1'b1;
        else if (dbg_exit)                 dbg_active <= 1'b0;
    end

    // First-instruction flag: set on exit, cleared by one retire.
    always_ff @(posedge clk) begin
        if (!rst_n)                              first_after_dbg <= 1'b0;
        else if (dbg_active && dbg_exit && !dbg_enter) first_after_dbg <= 1'b1;
        else if (instr_retire)                   first_after_dbg <= 1'b0;
    end

    // Low-power enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          lp_en <= 1'b0;
        else if (force_full) lp_en <= 1'b0;
        else if (lp_clr_req) lp_en <= 1'b0;
        else if (set_ok)     lp_en <= 1'b1;
    end

    // Divide select: follows the enable on a divided boundary, or forced.
    always_ff @(posedge clk) begin
        if (!rst_n)          div_sel <= SEL_FULL;
        else if (force_full) div_sel <= SEL_FULL;
        else if (tick)       div_sel <= lp_en ? SEL_SLOW : SEL_FULL;
    end
endmodule

// File: rtl/clkdiv_divider.sv
// Divide counter: produces a boundary flag and a gated one-cycle tick per
// divided period. Holds its count while run is low. Assumes the select
// only changes on a tick or together with restart.
module clkdiv_divider
    import clkdiv_pkg::*;
#(
    parameter int DIV_SLOW_RATIO = 256
) (
    input  logic     clk,
    input  logic     rst_n,
    input  div_sel_e div_sel,
    input  logic     run,
    input  logic     restart,
    output logic     at_bound,
    output logic     tick
);
    localparam int CNT_W = (DIV_SLOW_RATIO > 2) ? $clog2(DIV_SLOW_RATIO) : 1;
    localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(DIV_SLOW_RATIO - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // Boundary decode for the current ratio.
    always_comb begin
        lim      = (div_sel == SEL_SLOW) ? SLOW_LIM : '0;
        at_bound = (cnt == lim);
        tick     = run && at_bound;
    end

    // Period counter, frozen while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (run)          cnt <= at_bound ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/clkdiv_warmup.sv
// Crystal warmup and source switch: counts WARM_CYCLES after a request
// (never frozen), then swaps the source when switch_ok allows and strobes.
// A new request during warmup restarts the count.
module clkdiv_warmup #(
    parameter int WARM_CYCLES = 64,
    parameter int SRC_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_req,
    input  logic [SRC_W-1:0] src_target,
    input  logic             switch_ok,
    output logic [SRC_W-1:0] active_src,
    output logic             switch_stb
);
    localparam int WCNT_W = $clog2(WARM_CYCLES + 1);
    localparam logic [WCNT_W-1:0] WLAST = WCNT_W'(WARM_CYCLES - 1);

    logic              busy;
    logic              pending;
    logic [WCNT_W-1:0] wcnt;
    logic [SRC_W-1:0]  target_q;

    // Warmup counter and pending-switch state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            pending  <= 1'b0;
            wcnt     <= '0;
            target_q <= '0;
        end else if (src_req) begin
            busy     <= 1'b1;
            pending  <= 1'b0;
            wcnt     <= '0;
            target_q <= src_target;
        end else if (busy) begin
            if (wcnt == WLAST) begin
                busy    <= 1'b0;
                pending <= 1'b1;
            end
            wcnt <= wcnt + 1'b1;
        end else if (pending && switch_ok) begin
            pending <= 1'b0;
        end
    end

    // Source register and strobe, updated together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_src <= '0;
            switch_stb <= 1'b0;
        end else begin
            switch_stb <= pending && switch_ok && !src_req;
            if (pending && switch_ok && !src_req) active_src <= target_q;
        end
    end
endmodule

// File: rtl/clkdiv_dbg_ctrl.sv
// Top: debug-aware clock divide controller. Combines mode control, the
// divide counter and the warmup/source switch. Clock is gated whenever
// debug is active and no debug command is executing.
module clkdiv_dbg_ctrl
    import clkdiv_pkg::*;
#(
    parameter int DIV_SLOW_RATIO = 256,
    parameter int WARM_CYCLES    = 64,
    parameter int SRC_W          = 2,
    localparam int RATIO_W       = $clog2(DIV_SLOW_RATIO + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lp_set_req,
    input  logic               lp_clr_req,
    input  logic               swb_en,
    input  logic               bkpt_hit,
    input  logic               host_dbg_req,
    input  logic               dbg_exit,
    input  logic               dbg_cmd_busy,
    input  logic               instr_retire,
    input  logic               src_req,
    input  logic [SRC_W-1:0]   src_target,
    output logic [RATIO_W-1:0] div_ratio,
    output logic               clk_en,
    output logic               lowpwr_on,
    output logic [SRC_W-1:0]   active_src,
    output logic               src_switch_stb
);
    logic     dbg_enter;
    logic     dbg_active;
    logic     first_after_dbg;
    logic     force_full;
    logic     run;
    logic     at_bound;
    logic     tick;
    div_sel_e div_sel;

    // Event merge and gating decode.
    always_comb begin
        dbg_enter = bkpt_hit || host_dbg_req;
        run       = !dbg_active || dbg_cmd_busy;
        clk_en    = tick;
        div_ratio = (div_sel == SEL_SLOW) ? RATIO_W'(DIV_SLOW_RATIO) : RATIO_W'(1);
    end

    clkdiv_mode_ctrl u_mode (
        .clk             (clk),
        .rst_n           (rst_n),
        .lp_set_req      (lp_set_req),
        .lp_clr_req      (lp_clr_req),
        .swb_en          (swb_en),
        .dbg_enter       (dbg_enter),
        .dbg_exit        (dbg_exit),
        .instr_retire    (instr_retire),
        .tick            (tick),
        .dbg_active      (dbg_active),
        .first_after_dbg (first_after_dbg),
        .lp_en           (lowpwr_on),
        .force_full      (force_full),
        .div_sel         (div_sel)
    );

    clkdiv_divider #(.DIV_SLOW_RATIO(DIV_SLOW_RATIO)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (div_sel),
        .run      (run),
        .restart  (force_full),
        .at_bound (at_bound),
        .tick     (tick)
    );

    clkdiv_warmup #(.WARM_CYCLES(WARM_CYCLES), .SRC_W(SRC_W)) u_warm (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_req    (src_req),
        .src_target (src_target),
        .switch_ok  (tick || !run),
        .active_src (active_src),
        .switch_stb (src_switch_stb)
    );
endmodule

// File: rtl/clkdiv_dbg_ctrl_chk.sv
// Property checker for clkdiv_dbg_ctrl, attached by bind below.
module clkdiv_dbg_ctrl_chk #(
    parameter int DIV_SLOW_RATIO = 256,
    parameter int SRC_W          = 2,
    parameter int RATIO_W        = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lp_set_req,
    input logic               swb_en,
    input logic               bkpt_hit,
    input logic               host_dbg_req,
    input logic               dbg_cmd_busy,
    input logic               dbg_active,
    input logic               first_after_dbg,
    input logic [RATIO_W-1:0] div_ratio,
    input logic               clk_en,
    input logic               lowpwr_on,
    input logic [SRC_W-1:0]   active_src,
    input logic               src_switch_stb
);
    p_ratio_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_ratio == RATIO_W'(1) || div_ratio == RATIO_W'(DIV_SLOW_RATIO));

    p_ratio_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ratio != $past(div_ratio)) && !$past((bkpt_hit || host_dbg_req) && swb_en)
        |-> $past(clk_en));

    p_switchback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bkpt_hit || host_dbg_req) && swb_en |=> div_ratio == RATIO_W'(1) && !lowpwr_on);

    p_gated_in_debug_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_active && !dbg_cmd_busy |-> !clk_en);

    p_first_instr_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        first_after_dbg && lp_set_req && !lowpwr_on |=> !lowpwr_on);

    p_stb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        src_switch_stb |=> !src_switch_stb);

    p_src_with_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_src != $past(active_src)) |-> src_switch_stb);
endmodule

bind clkdiv_dbg_ctrl clkdiv_dbg_ctrl_chk #(
    .DIV_SLOW_RATIO (DIV_SLOW_RATIO),
    .SRC_W          (SRC_W),
    .RATIO_W        (RATIO_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .lp_set_req      (lp_set_req),
    .swb_en          (swb_en),
    .bkpt_hit        (bkpt_hit),
    .host_dbg_req    (host_dbg_req),
    .dbg_cmd_busy    (dbg_cmd_busy),
    .dbg_active      (dbg_active),
    .first_after_dbg (first_after_dbg),
    .div_ratio       (div_ratio),
    .clk_en          (clk_en),
    .lowpwr_on       (lowpwr_on),
    .active_src      (active_src),
    .src_switch_stb  (src_switch_stb)
);

// File: tb/clkdiv_dbg_ctrl_tb.sv
// Directed bench: one task per scenario, inputs driven and outputs sampled
// at falling edges.
module clkdiv_dbg_ctrl_tb;
    localparam int SLOW  = 256;
    localparam int WARM  = 64;
    localparam int SRC_W = 2;
    localparam int RW    = $clog2(SLOW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_set_req = 0, lp_clr_req = 0, swb_en = 0, bkpt_hit = 0;
    logic host_dbg_req = 0, dbg_exit = 0, dbg_cmd_busy = 0, instr_retire = 0;
    logic src_req = 0;
    logic [SRC_W-1:0] src_target = '0;
    logic [RW-1:0]    div_ratio;
    logic             clk_en, lowpwr_on, src_switch_stb;
    logic [SRC_W-1:0] active_src;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    clkdiv_dbg_ctrl #(.DIV_SLOW_RATIO(SLOW), .WARM_CYCLES(WARM), .SRC_W(SRC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .lp_set_req(lp_set_req), .lp_clr_req(lp_clr_req),
        .swb_en(swb_en), .bkpt_hit(bkpt_hit), .host_dbg_req(host_dbg_req),
        .dbg_exit(dbg_exit), .dbg_cmd_busy(dbg_cmd_busy), .instr_retire(instr_retire),
        .src_req(src_req), .src_target(src_target), .div_ratio(div_ratio),
        .clk_en(clk_en), .lowpwr_on(lowpwr_on), .active_src(active_src),
        .src_switch_stb(src_switch_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Enter low power from divide 1 (flag clear, not in debug).
    task automatic t_enter_lowpwr();
        lp_set_req = 1; step(1); lp_set_req = 0;
        check("R2 lowpwr after one edge", lowpwr_on, 1);
        check("R2 ratio not yet changed", div_ratio, 1);
        step(1);
        check("R2 ratio 256", div_ratio, SLOW);
    endtask

    // Clear low power and confirm the return waits for a boundary.
    task automatic t_exit_lowpwr();
        int waited = 0;
        logic prev_en;
        prev_en = clk_en;
        lp_clr_req = 1; step(1); lp_clr_req = 0;
        check("R4 lowpwr cleared", lowpwr_on, 0);
        for (int i = 0; i < 300 && div_ratio != RW'(1); i++) begin
            prev_en = clk_en;
            step(1);
            waited++;
        end
        check("R4 returned to divide 1", div_ratio, 1);
        check("R4 change follows clk_en pulse", prev_en, 1);
    endtask

    task automatic t_reset();
        rst_n = 0; step(3); rst_n = 1; step(1);
        check("R1 ratio", div_ratio, 1);
        check("R1 clk_en", clk_en, 1);
        check("R1 lowpwr", lowpwr_on, 0);
        check("R1 src", active_src, 0);
        check("R1 stb", src_switch_stb, 0);
    endtask

    task automatic t_lowpwr_pulses();
        int ones = 0;
        int full_ones = 0;
        for (int i = 0; i < 8; i++) begin full_ones += clk_en; step(1); end
        check("R3 divide-1 pulses every cycle", full_ones, 8);
        t_enter_lowpwr();
        for (int i = 0; i < 2 * SLOW; i++) begin ones += clk_en; step(1); end
        check("R3 two pulses in 512 cycles", ones, 2);
        t_exit_lowpwr();
    endtask

    task automatic t_mid_reset();
        t_enter_lowpwr();
        rst_n = 0; step(2); rst_n = 1; step(1);
        check("R1 ratio after mid reset", div_ratio, 1);
        check("R1 lowpwr after mid reset", lowpwr_on, 0);
    endtask

    // Switchback by breakpoint, gating, refused requests, first-instr rule.
    task automatic t_switchback_bkpt();
        int busy_ones = 0;
        t_enter_lowpwr();
        swb_en = 1; bkpt_hit = 1; step(1); bkpt_hit = 0;
        check("R5 bkpt ratio forced 1", div_ratio, 1);
        check("R5 bkpt lowpwr cleared", lowpwr_on, 0);
        check("R6 gated without command", clk_en, 0);
        dbg_cmd_busy = 1;
        for (int i = 0; i < 4; i++) begin step(1); busy_ones += clk_en; end
        check("R6 clock runs during command", busy_ones, 4);
        dbg_cmd_busy = 0; step(1);
        check("R6 gated again after command", clk_en, 0);
        lp_set_req = 1; step(1); lp_set_req = 0; step(1);
        check("R8 set ignored in debug", lowpwr_on, 0);
        dbg_exit = 1; step(1); dbg_exit = 0;
        check("R6 ungated after exit", clk_en, 1);
        lp_set_req = 1; step(1); lp_set_req = 0; step(1);
        check("R8 set ignored on first instruction", lowpwr_on, 0);
        instr_retire = 1; step(1); instr_retire = 0;
        t_enter_lowpwr();
        check("R8 set accepted after retire", lowpwr_on, 1);
        t_exit_lowpwr();
    endtask

    task automatic t_switchback_host();
        t_enter_lowpwr();
        swb_en = 1; host_dbg_req = 1; step(1); host_dbg_req = 0;
        check("R5 host ratio forced 1", div_ratio, 1);
        check("R5 host lowpwr cleared", lowpwr_on, 0);
        dbg_exit = 1; step(1); dbg_exit = 0;
        instr_retire = 1; step(1); instr_retire = 0;
    endtask

    task automatic t_no_switchback();
        int ones = 0;
        t_enter_lowpwr();
        swb_en = 0; bkpt_hit = 1; step(1); bkpt_hit = 0;
        check("R7 ratio kept 256", div_ratio, SLOW);
        check("R7 lowpwr kept", lowpwr_on, 1);
        for (int i = 0; i < SLOW + 20; i++) begin ones += clk_en; step(1); end
        check("R6 no pulse while gated at 256", ones, 0);
        dbg_exit = 1; step(1); dbg_exit = 0;
        instr_retire = 1; step(1); instr_retire = 0;
        t_exit_lowpwr();
    endtask

    task automatic t_warmup_full();
        int stb_at = 0;
        src_target = 2'd2; src_req = 1; step(1); src_req = 0;
        for (int i = 1; i <= WARM + 3; i++) begin
            if (src_switch_stb && stb_at == 0) stb_at = i;
            if (i < WARM + 3) step(1);
        end
        check("R9 strobe sample index", stb_at, WARM + 2);
        check("R9 new source", active_src, 2);
        check("R9 strobe single cycle", src_switch_stb, 0);
    endtask

    task automatic t_warmup_in_debug();
        int stb_at = 0;
        t_enter_lowpwr();
        swb_en = 0; bkpt_hit = 1; step(1); bkpt_hit = 0;
        src_target = 2'd1; src_req = 1; step(1); src_req = 0;
        for (int i = 1; i <= WARM + 2; i++) begin
            if (src_switch_stb && stb_at == 0) stb_at = i;
            if (i < WARM + 2) step(1);
        end
        check("R10 switch in gated debug", stb_at, WARM + 2);
        check("R10 source in debug", active_src, 1);
        check("R10 clock still gated", clk_en, 0);
        dbg_exit = 1; step(1); dbg_exit = 0;
        instr_retire = 1; step(1); instr_retire = 0;
        t_exit_lowpwr();
    endtask

    task automatic t_warmup_slow();
        logic prev_en = 1'b0;
        logic seen = 1'b0;
        t_enter_lowpwr();
        src_target = 2'd3; src_req = 1; step(1); src_req = 0;
        for (int i = 0; i < WARM + SLOW + 8 && !seen; i++) begin
            prev_en = clk_en;
            step(1);
            seen = src_switch_stb;
        end
        check("R10 strobe seen at 256", seen, 1);
        check("R10 strobe after boundary", prev_en, 1);
        check("R10 source at 256", active_src, 3);
        t_exit_lowpwr();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(1);
        t_reset();
        t_lowpwr_pulses();
        t_mid_reset();
        t_switchback_bkpt();
        t_switchback_host();
        t_no_switchback();
        t_warmup_full();
        t_warmup_in_debug();
        t_warmup_slow();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule